// File: doc/BRIEF.md
# Single-Error-Correcting Decoder for a Systematic (7,4) Block Code

This block receives one 7-bit word of a systematic (7,4) linear block code per valid cycle and returns the 4 information bits it most likely carried. It multiplies the word by a fixed 3x7 parity-check matrix over GF(2) to get a 3-bit syndrome. A zero syndrome passes the word through untouched. A non-zero syndrome is matched against the matrix columns. The single bit whose column equals it is inverted, and the leading four bits of the repaired word are delivered.

The matrix columns are not the binary numbers 1..7 in position order. The syndrome therefore cannot be used directly as a bit index. A small lookup built from the matrix columns translates it into an error pattern. The block presents the decoded data, the syndrome and a repair flag one clock after the input strobe. It sits directly behind a hard-decision demodulator or deframer.

Each of the seven non-zero syndromes names exactly one bit, so the block never reports a word as uncorrectable. Two flipped bits produce a wrong but valid codeword and raise the repair flag. Three flips that land on another codeword pass unnoticed.

Top module: `syn_dec74`

## Requirements
- R1: Bit position p (1..7) of a received word is carried on `inWord[7-p]`. Positions 1..4 are the data and 5..7 the parity. `outData[3]` carries position 1 and `outData[0]` carries position 4.
- R2: `outSyndrome[2]` is the XOR of the word bits selected by mask 1110100, `outSyndrome[1]` of mask 0111010 and `outSyndrome[0]` of mask 1101001. Each mask is written with position 1 leftmost.
- R3: When the syndrome is 000, `outData` equals positions 1..4 of the received word and `outCorrected` is 0.
- R4: When the syndrome is non-zero, exactly one position is inverted before the data is taken, and `outCorrected` is 1. The syndrome selects the position as follows: 101 selects 1, 111 selects 2, 110 selects 3, 011 selects 4, 100 selects 5, 010 selects 6 and 001 selects 7.
- R5: Results appear on the clock edge that samples `inValid` high, so they are visible one cycle after the input is presented. `outValid` repeats `inValid` delayed by one cycle.
- R6: In a cycle where `inValid` is low, the next `outValid` is 0 and `outData`, `outSyndrome` and `outCorrected` keep their values.
- R7: A synchronous, active-high `rst` takes priority over `inValid`. On the following edge it clears `outValid`, `outCorrected`, `outSyndrome` and `outData` to zero.
- R8: Input 1000101 (position 1 leftmost) decodes to data 1000 with syndrome 000.
- R9: Input 0100111 is the codeword 1000101 with positions 1, 2 and 6 flipped. It decodes to 0100 with syndrome 000 and `outCorrected` at 0.
- R10: A double error is repaired to a different codeword with the flag set. Input 0100101 (1000101 with positions 1 and 2 flipped) gives syndrome 010 and data 0100, with `outCorrected` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Received word is present this cycle |
| inWord | input | 7 | Received word, position 1 in bit 6 |
| outValid | output | 1 | Decoded result is present |
| outData | output | 4 | Recovered information bits, position 1 in bit 3 |
| outSyndrome | output | 3 | Syndrome of the received word |
| outCorrected | output | 1 | A bit was inverted to form this result |

## Verification
A bad entry in the syndrome-to-position lookup appears at the ports on the first output of the single-bit error that uses it: the wrong bit gets flipped, or the right data bit is left alone. A wrong parity mask row shows up as a wrong syndrome on the first word whose bits touch that row, one cycle after it enters. The bench runs every data value with each single-bit error, so every lookup entry and every mask bit is exercised. A stuck load or clear strobe between control and datapath appears on the first idle or reset cycle as output that changes when it should hold, or stays when it should clear.

// File: rtl/syn_dec74_pkg.sv
package syn_dec74_pkg;

  localparam int CODE_N  = 7;
  localparam int DATA_K  = 4;
  localparam int CHECK_M = CODE_N - DATA_K;

  // Parity-check rows, position 1 in the MSB; row 0 gives the syndrome MSB
  localparam logic [CODE_N-1:0] CHECK_ROWS [CHECK_M] = '{
    7'b1110100,
    7'b0111010,
    7'b1101001
  };

  typedef struct packed {
    logic load;   // capture a new decoded result
    logic clear;  // return result registers to zero
  } ctrlStrobe_t;

endpackage

// File: rtl/syn_dec74_syndrome.sv
module syn_dec74_syndrome #(
  parameter int N = syn_dec74_pkg::CODE_N,
  parameter int K = syn_dec74_pkg::DATA_K,
  parameter logic [N-1:0] ROWS [N-K] = syn_dec74_pkg::CHECK_ROWS,
  localparam int M = N - K
) (
  input  logic [N-1:0] word,
  output logic [M-1:0] syndrome
);

  for (genvar r = 0; r < M; r++) begin : g_row
    assign syndrome[M-1-r] = ^(word & ROWS[r]);
  end

endmodule

// File: rtl/syn_dec74_errmap.sv
module syn_dec74_errmap #(
  parameter int N = syn_dec74_pkg::CODE_N,
  parameter int K = syn_dec74_pkg::DATA_K,
  parameter logic [N-1:0] ROWS [N-K] = syn_dec74_pkg::CHECK_ROWS,
  localparam int M = N - K
) (
  input  logic [M-1:0] syndrome,
  output logic [N-1:0] errVec
);

  // Column of the check matrix for bit index idx (idx N-1 = position 1)
  function automatic logic [M-1:0] columnOf(input int idx);
    logic [M-1:0] col;
    for (int r = 0; r < M; r++) begin
      col[M-1-r] = ROWS[r][idx];
    end
    return col;
  endfunction

  for (genvar b = 0; b < N; b++) begin : g_pos
    localparam logic [M-1:0] COL = columnOf(b);
    assign errVec[b] = (syndrome != '0) && (syndrome == COL);
  end

endmodule

// File: rtl/syn_dec74_datapath.sv
module syn_dec74_datapath
  import syn_dec74_pkg::*;
#(
  parameter int N = CODE_N,
  parameter int K = DATA_K,
  parameter logic [N-1:0] ROWS [N-K] = CHECK_ROWS,
  localparam int M = N - K
) (
  input  logic        clk,
  input  ctrlStrobe_t strobe,
  input  logic [N-1:0] inWord,
  output logic [K-1:0] outData,
  output logic [M-1:0] outSyndrome,
  output logic         outCorrected
);

  logic [M-1:0] syndrome;
  logic [N-1:0] errVec;
  logic [N-1:0] fixedWord;

  syn_dec74_syndrome #(.N(N), .K(K), .ROWS(ROWS)) u_syndrome (
    .word     (inWord),
    .syndrome (syndrome)
  );

  syn_dec74_errmap #(.N(N), .K(K), .ROWS(ROWS)) u_errmap (
    .syndrome (syndrome),
    .errVec   (errVec)
  );

  assign fixedWord = inWord ^ errVec;

  always_ff @(posedge clk) begin
    if (strobe.clear) begin
      outData      <= '0;
      outSyndrome  <= '0;
      outCorrected <= 1'b0;
    end else if (strobe.load) begin
      outData      <= fixedWord[N-1 -: K];
      outSyndrome  <= syndrome;
      outCorrected <= |errVec;
    end
  end

endmodule

// File: rtl/syn_dec74_control.sv
module syn_dec74_control
  import syn_dec74_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  output ctrlStrobe_t strobe,
  output logic        outValid
);

  assign strobe.clear = rst;
  assign strobe.load  = inValid && !rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
    end else begin
      outValid <= inValid;
    end
  end

endmodule

// File: rtl/syn_dec74.sv
module syn_dec74
  import syn_dec74_pkg::*;
#(
  parameter int N = CODE_N,
  parameter int K = DATA_K,
  localparam int M = N - K
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  input  logic [N-1:0] inWord,
  output logic         outValid,
  output logic [K-1:0] outData,
  output logic [M-1:0] outSyndrome,
  output logic         outCorrected
);

  ctrlStrobe_t strobe;

  syn_dec74_control u_control (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .strobe   (strobe),
    .outValid (outValid)
  );

  syn_dec74_datapath #(.N(N), .K(K)) u_datapath (
    .clk          (clk),
    .strobe       (strobe),
    .inWord       (inWord),
    .outData      (outData),
    .outSyndrome  (outSyndrome),
    .outCorrected (outCorrected)
  );

endmodule

// File: rtl/syn_dec74_chk.sv
module syn_dec74_chk
  import syn_dec74_pkg::*;
(
  input logic                clk,
  input logic                rst,
  input logic                inValid,
  input logic [CODE_N-1:0]   inWord,
  input logic                outValid,
  input logic [DATA_K-1:0]   outData,
  input logic [CHECK_M-1:0]  outSyndrome,
  input logic                outCorrected
);

  logic cleanIn;
  assign cleanIn = !(^(inWord & CHECK_ROWS[0])) &&
                   !(^(inWord & CHECK_ROWS[1])) &&
                   !(^(inWord & CHECK_ROWS[2]));

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && $stable(outData) && $stable(outSyndrome) && $stable(outCorrected)));

  // R4
  flag_match_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> (outCorrected == (outSyndrome != '0)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && !outCorrected && outSyndrome == '0 && outData == '0));

  // R3
  clean_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && cleanIn) |=> (outData == $past(inWord[CODE_N-1 -: DATA_K]) && !outCorrected));

endmodule

bind syn_dec74 syn_dec74_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .inValid      (inValid),
  .inWord       (inWord),
  .outValid     (outValid),
  .outData      (outData),
  .outSyndrome  (outSyndrome),
  .outCorrected (outCorrected)
);

// File: tb/syn_dec74_bench.sv
module syn_dec74_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       inValid = 1'b0;
  logic [6:0] inWord = '0;
  logic       outValid;
  logic [3:0] outData;
  logic [2:0] outSyndrome;
  logic       outCorrected;

  int compared = 0;
  int mismatched = 0;
  int cycleCount = 0;
  bit done = 1'b0;

  string curTag = "R7";
  string modelTag = "R7";

  // Expected model state
  logic       expValid = 1'b0;
  logic [3:0] expData = '0;
  logic [2:0] expSyn = '0;
  logic       expCorr = 1'b0;

  // Syndrome value signalled by an error at position 1..7 (index 0 = position 1)
  localparam logic [2:0] COLTAB [7] = '{3'b101, 3'b111, 3'b110, 3'b011, 3'b100, 3'b010, 3'b001};

  always #2 clk = ~clk;

  syn_dec74 u_syn_dec74 (
    .clk          (clk),
    .rst          (rst),
    .inValid      (inValid),
    .inWord       (inWord),
    .outValid     (outValid),
    .outData      (outData),
    .outSyndrome  (outSyndrome),
    .outCorrected (outCorrected)
  );

  function automatic logic [2:0] refSyn(input logic [6:0] w);
    logic [2:0] s = '0;
    for (int p = 1; p <= 7; p++) begin
      if (w[7-p]) s = s ^ COLTAB[p-1];
    end
    return s;
  endfunction

  function automatic logic [6:0] refFix(input logic [6:0] w);
    logic [2:0] s = refSyn(w);
    logic [6:0] f = w;
    if (s != 3'b000) begin
      for (int p = 1; p <= 7; p++) begin
        if (COLTAB[p-1] == s) f[7-p] = ~f[7-p];
      end
    end
    return f;
  endfunction

  function automatic logic [6:0] encode(input logic [3:0] d);
    logic [6:0] cw = '0;
    for (int par = 0; par < 8; par++) begin
      if (refSyn({d, par[2:0]}) == 3'b000) cw = {d, par[2:0]};
    end
    return cw;
  endfunction

  // Reference model, one step per rising edge
  always @(posedge clk) begin
    cycleCount++;
    modelTag = curTag;
    if (rst) begin
      expValid = 1'b0;
      expData  = '0;
      expSyn   = '0;
      expCorr  = 1'b0;
    end else if (inValid) begin
      logic [6:0] f;
      f = refFix(inWord);
      expValid = 1'b1;
      expSyn   = refSyn(inWord);
      expData  = f[6:3];
      expCorr  = (expSyn != 3'b000);
    end else begin
      expValid = 1'b0;
    end
  end

  // Compare every cycle away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      compared++;
      if (outValid !== expValid || outData !== expData ||
          outSyndrome !== expSyn || outCorrected !== expCorr) begin
        mismatched++;
        $display("FAIL %s: actual v=%b d=%b s=%b c=%b expected v=%b d=%b s=%b c=%b",
                 modelTag, outValid, outData, outSyndrome, outCorrected,
                 expValid, expData, expSyn, expCorr);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycleCount > 20000 && !done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL R5: watchdog expired, actual cycles=%0d expected below 20000", cycleCount);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic drive(input logic v, input logic [6:0] w, input string tag);
    @(negedge clk);
    inValid = v;
    inWord  = w;
    curTag  = tag;
  endtask

  task automatic directed(input logic [6:0] w, input logic [3:0] d, input logic [2:0] s,
                          input logic c, input string tag);
    drive(1'b1, w, tag);
    @(posedge clk);
    #1;
    compared++;
    if (outValid !== 1'b1 || outData !== d || outSyndrome !== s || outCorrected !== c) begin
      mismatched++;
      $display("FAIL %s: actual v=%b d=%b s=%b c=%b expected v=1 d=%b s=%b c=%b",
               tag, outValid, outData, outSyndrome, outCorrected, d, s, c);
    end
  endtask

  initial begin
    // R7: reset dominates a valid input
    inValid = 1'b1;
    inWord  = 7'b1111111;
    repeat (3) @(negedge clk);
    drive(1'b0, 7'b0000000, "R7");
    rst = 1'b0;

    // R3, R1, R2: clean codewords; R4: every single-bit error
    for (int d = 0; d < 16; d++) begin
      for (int e = 0; e <= 7; e++) begin
        logic [6:0] w;
        w = encode(d[3:0]);
        if (e != 0) w[7-e] = ~w[7-e];
        drive(1'b1, w, (e == 0) ? "R3" : "R4");
      end
      // R6: idle cycle with changing data must not disturb outputs
      drive(1'b0, 7'(d * 9 + 5), "R6");
    end

    // R5: back-to-back words after an idle gap
    drive(1'b0, 7'b1010101, "R6");
    drive(1'b1, 7'b0011100, "R5");
    drive(1'b1, 7'b1100011, "R5");

    // Directed cases
    directed(7'b1000101, 4'b1000, 3'b000, 1'b0, "R8");
    directed(7'b0100111, 4'b0100, 3'b000, 1'b0, "R9");
    directed(7'b0100101, 4'b0100, 3'b010, 1'b1, "R10");
    directed(7'b0000001, 4'b0000, 3'b001, 1'b1, "R1");
    directed(7'b1000000, 4'b0000, 3'b101, 1'b1, "R2");

    // R7: mid-stream reset with a valid word present
    @(negedge clk);
    rst = 1'b1;
    inValid = 1'b1;
    inWord = 7'b0111001;
    curTag = "R7";
    @(negedge clk);
    rst = 1'b0;
    drive(1'b0, 7'b0, "R6");
    drive(1'b0, 7'b0, "R6");

    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule